// File: doc/BRIEF.md
# Configurable Boolean Pattern Match Engine

This block watches a set of input lines and evaluates a programmable sum-of-products expression over them. The expression is built from bit slices. Each slice picks one input line through its own source field and tests it with its own condition code. A condition can be a level, a constant, a one-clock edge event, or a sticky edge that stays latched. Slices placed next to each other are ANDed into a product term, and each term closes at a slice flagged as an endpoint. The last slice always closes a term.

The match of each product term is reported at the bit position of its endpoint slice. That vector can replace the normal pin interrupts, it can raise a one-clock receive-event pulse when some term starts to match, and it can be read live from the control register. The engine is configured through a small register write port and observed through a registered read port.

Top module: `pattern_match_engine`

## Requirements
- R1: Slice i takes its source from bits [3i+2:3i] of the source register (address 1). A value of n selects input line n.
- R2: The condition of slice i sits in bits [8+3i+2:8+3i] of the config register (address 2). Code 000 is true while the input is high, 101 while it is low, 100 is always true and 110 is never true. A level match shows on the outputs one clock edge after the input is applied.
- R3: Code 111 matches for exactly one clock after a rising or falling edge of the selected input.
- R4: Code 001 latches a rising edge, 010 a falling edge and 011 an edge in either direction. A latched slice keeps matching until it is cleared, and a code that does not watch the edge that occurred stays false.
- R5: A write to the source register clears the sticky latch of every slice whose written field is nonzero or differs from its current value. A write to the config register clears the latch of every slice whose condition field changes. A source write of an unchanged zero field leaves the latch set.
- R6: Config bits [6:0] flag slices 0 to 6 as endpoints, and slice 7 is always an endpoint. A product term is the AND of the slices that follow the previous endpoint (or start at slice 0), up to and including its endpoint. Its match appears at bit position equal to that endpoint.
- R7: When control bit 0 (address 0) is set, irq_out equals the registered match vector. When it is clear, irq_out is normal_irq delayed by one clock.
- R8: When control bit 1 is set, rx_event pulses high for one clock in the cycle in which the OR of all term matches rises. When the bit is clear, rx_event stays low.
- R9: match_status shows the live term matches, with only endpoint positions ever high. A read of address 0 returns match_status in bits [31:24] and the control bits in [1:0]. Read data appears one clock edge after rd_addr is applied, and a read of address 1 or 2 returns the word last written there.
- R10: Reset is synchronous and active high. It clears all registers and outputs and loads the input history, so an input level held through reset produces no edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_lines | input | 8 | Watched input lines (already synchronised) |
| normal_irq | input | 8 | Interrupts from the normal pin path |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 source, 2 config |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Registered read data |
| irq_out | output | 8 | Selected pin interrupt vector |
| rx_event | output | 1 | One-clock pulse when some term starts to match |
| match_status | output | 8 | Live term matches at endpoint positions |

## Verification
An input applied before a rising edge shows up in match_status, irq_out and rx_event right after that edge, one register stage in all. An event match then clears at the following edge, while a sticky or level match remains. The bench changes inputs at a falling edge and samples at the next falling edge for the first result, then one edge later for the held or expired value. A latch clear caused by a register write lands at the write edge, so the outputs only show it one edge after that. Read data is likewise checked one falling edge after rd_addr is driven.

// File: rtl/pme_pkg.sv
package pme_pkg;

  typedef enum logic [2:0] {
    COND_HIGH       = 3'b000,
    COND_RISE_LATCH = 3'b001,
    COND_FALL_LATCH = 3'b010,
    COND_BOTH_LATCH = 3'b011,
    COND_ALWAYS     = 3'b100,
    COND_LOW        = 3'b101,
    COND_NEVER      = 3'b110,
    COND_EDGE_PULSE = 3'b111
  } cond_e;

  localparam int COND_W = 3;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_SRC  = 2'd1;
  localparam logic [1:0] ADDR_CFG  = 2'd2;

  localparam int CTRL_IRQ_SEL = 0;
  localparam int CTRL_RX_EN   = 1;

endpackage

// File: rtl/pme_regs.sv
module pme_regs
  import pme_pkg::*;
#(
  parameter int N_SLICES = 8,
  parameter int SRC_W    = 3,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [DATA_W-1:0]                  wr_data,
  input  logic [ADDR_W-1:0]                  rd_addr,
  input  logic [N_SLICES-1:0]                status,
  output logic [DATA_W-1:0]                  rd_data,
  output logic [N_SLICES-1:0][SRC_W-1:0]     src_sel,
  output logic [N_SLICES-1:0][COND_W-1:0]    cond,
  output logic [N_SLICES-2:0]                ep_flags,
  output logic                               irq_sel,
  output logic                               rx_en,
  output logic [N_SLICES-1:0]                sticky_clr
);

  localparam int COND_BASE = N_SLICES;
  localparam int STAT_LSB  = DATA_W - N_SLICES;

  logic [DATA_W-1:0] src_q;
  logic [DATA_W-1:0] cfg_q;
  logic [1:0]        ctrl_q;
  logic              src_wr;
  logic              cfg_wr;
  logic              ctrl_wr;

  assign src_wr  = wr_en && (wr_addr == ADDR_W'(ADDR_SRC));
  assign cfg_wr  = wr_en && (wr_addr == ADDR_W'(ADDR_CFG));
  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      cfg_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (src_wr)  src_q  <= wr_data;
      if (cfg_wr)  cfg_q  <= wr_data;
      if (ctrl_wr) ctrl_q <= wr_data[1:0];
    end
  end

  for (genvar i = 0; i < N_SLICES; i++) begin : g_field
    logic [SRC_W-1:0]  src_new;
    logic [COND_W-1:0] cond_new;
    assign src_new       = wr_data[i*SRC_W +: SRC_W];
    assign cond_new      = wr_data[COND_BASE + i*COND_W +: COND_W];
    assign src_sel[i]    = src_q[i*SRC_W +: SRC_W];
    assign cond[i]       = cfg_q[COND_BASE + i*COND_W +: COND_W];
    assign sticky_clr[i] = (src_wr && ((src_new != '0) || (src_new != src_sel[i])))
                         || (cfg_wr && (cond_new != cond[i]));
  end

  assign ep_flags = cfg_q[N_SLICES-2:0];
  assign irq_sel  = ctrl_q[CTRL_IRQ_SEL];
  assign rx_en    = ctrl_q[CTRL_RX_EN];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        ADDR_W'(ADDR_CTRL): begin
          rd_data                       <= '0;
          rd_data[1:0]                  <= ctrl_q;
          rd_data[STAT_LSB +: N_SLICES] <= status;
        end
        ADDR_W'(ADDR_SRC): rd_data <= src_q;
        ADDR_W'(ADDR_CFG): rd_data <= cfg_q;
        default:           rd_data <= '0;
      endcase
    end
  end

endmodule

// File: rtl/pme_slice.sv
module pme_slice
  import pme_pkg::*;
#(
  parameter int N_INPUTS = 8,
  parameter int SRC_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_INPUTS-1:0] in_now,
  input  logic [N_INPUTS-1:0] in_prev,
  input  logic [SRC_W-1:0]    src_sel,
  input  logic [COND_W-1:0]   cond,
  input  logic                clr,
  output logic                hit
);

  cond_e code;
  logic  cur_bit;
  logic  old_bit;
  logic  rise;
  logic  fall;
  logic  arm;
  logic  latched;

  assign code    = cond_e'(cond);
  assign cur_bit = in_now[src_sel];
  assign old_bit = in_prev[src_sel];
  assign rise    = cur_bit & ~old_bit;
  assign fall    = ~cur_bit & old_bit;

  always_comb begin
    case (code)
      COND_RISE_LATCH: arm = rise;
      COND_FALL_LATCH: arm = fall;
      COND_BOTH_LATCH: arm = rise | fall;
      default:         arm = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) latched <= 1'b0;
    else if (arm)   latched <= 1'b1;
  end

  always_comb begin
    case (code)
      COND_HIGH:       hit = cur_bit;
      COND_LOW:        hit = ~cur_bit;
      COND_ALWAYS:     hit = 1'b1;
      COND_NEVER:      hit = 1'b0;
      COND_EDGE_PULSE: hit = rise | fall;
      default:         hit = latched | arm;
    endcase
  end

endmodule

// File: rtl/pme_terms.sv
module pme_terms #(
  parameter int N_SLICES = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_SLICES-1:0] hit,
  input  logic [N_SLICES-2:0] ep_flags,
  input  logic                irq_sel,
  input  logic                rx_en,
  input  logic [N_SLICES-1:0] normal_irq,
  output logic [N_SLICES-1:0] match_q,
  output logic [N_SLICES-1:0] irq_q,
  output logic                rx_q
);

  logic [N_SLICES-1:0] ends;
  logic [N_SLICES-1:0] chain;
  logic [N_SLICES-1:0] match_now;

  assign ends = {1'b1, ep_flags};

  for (genvar i = 0; i < N_SLICES; i++) begin : g_chain
    if (i == 0) begin : g_first
      assign chain[i] = hit[i];
    end else begin : g_next
      assign chain[i] = hit[i] & (ends[i-1] | chain[i-1]);
    end
  end

  assign match_now = chain & ends;

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
      irq_q   <= '0;
      rx_q    <= 1'b0;
    end else begin
      match_q <= match_now;
      irq_q   <= irq_sel ? match_now : normal_irq;
      rx_q    <= rx_en && (|match_now) && !(|match_q);
    end
  end

endmodule

// File: rtl/pattern_match_engine.sv
module pattern_match_engine
  import pme_pkg::*;
#(
  parameter int N_SLICES = 8,
  parameter int N_INPUTS = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_INPUTS-1:0] in_lines,
  input  logic [N_SLICES-1:0] normal_irq,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic [N_SLICES-1:0] irq_out,
  output logic                rx_event,
  output logic [N_SLICES-1:0] match_status
);

  localparam int SRC_W = $clog2(N_INPUTS);

  logic [N_INPUTS-1:0]             in_prev;
  logic [N_SLICES-1:0][SRC_W-1:0]  src_sel;
  logic [N_SLICES-1:0][COND_W-1:0] cond;
  logic [N_SLICES-2:0]             ep_flags;
  logic                            irq_sel;
  logic                            rx_en;
  logic [N_SLICES-1:0]             sticky_clr;
  logic [N_SLICES-1:0]             hit;

  always_ff @(posedge clk) begin
    in_prev <= in_lines;
  end

  pme_regs #(
    .N_SLICES(N_SLICES),
    .SRC_W   (SRC_W),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .status    (match_status),
    .rd_data   (rd_data),
    .src_sel   (src_sel),
    .cond      (cond),
    .ep_flags  (ep_flags),
    .irq_sel   (irq_sel),
    .rx_en     (rx_en),
    .sticky_clr(sticky_clr)
  );

  for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
    pme_slice #(
      .N_INPUTS(N_INPUTS),
      .SRC_W   (SRC_W)
    ) u_slice (
      .clk    (clk),
      .rst    (rst),
      .in_now (in_lines),
      .in_prev(in_prev),
      .src_sel(src_sel[i]),
      .cond   (cond[i]),
      .clr    (sticky_clr[i]),
      .hit    (hit[i])
    );
  end

  pme_terms #(
    .N_SLICES(N_SLICES)
  ) u_terms (
    .clk       (clk),
    .rst       (rst),
    .hit       (hit),
    .ep_flags  (ep_flags),
    .irq_sel   (irq_sel),
    .rx_en     (rx_en),
    .normal_irq(normal_irq),
    .match_q   (match_status),
    .irq_q     (irq_out),
    .rx_q      (rx_event)
  );

endmodule

// File: rtl/pme_checker.sv
module pme_checker #(
  parameter int N_SLICES = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [N_SLICES-2:0] ep_flags,
  input logic                irq_sel,
  input logic                rx_en,
  input logic [N_SLICES-1:0] normal_irq,
  input logic [N_SLICES-1:0] irq_out,
  input logic                rx_event,
  input logic [N_SLICES-1:0] match_status
);

  assert_status_at_ends_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((match_status & ~{1'b1, $past(ep_flags)}) == '0));

  assert_rx_single_R8: assert property (@(posedge clk) disable iff (rst)
    rx_event |=> !rx_event);

  assert_rx_needs_match_R8: assert property (@(posedge clk) disable iff (rst)
    rx_event |-> (match_status != '0));

  assert_rx_gated_R8: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !rx_event);

  assert_irq_passthru_R7: assert property (@(posedge clk) disable iff (rst)
    !irq_sel |=> (irq_out == $past(normal_irq)));

  assert_irq_from_match_R7: assert property (@(posedge clk) disable iff (rst)
    irq_sel |=> (irq_out == match_status));

endmodule

bind pattern_match_engine pme_checker #(
  .N_SLICES(N_SLICES)
) i_pme_checker (
  .clk         (clk),
  .rst         (rst),
  .ep_flags    (ep_flags),
  .irq_sel     (irq_sel),
  .rx_en       (rx_en),
  .normal_irq  (normal_irq),
  .irq_out     (irq_out),
  .rx_event    (rx_event),
  .match_status(match_status)
);

// File: tb/test_pattern_match_engine.sv
`timescale 1ns/1ps
module test_pattern_match_engine;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  in_lines = '0;
  logic [7:0]  normal_irq = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [7:0]  irq_out;
  logic        rx_event;
  logic [7:0]  match_status;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  pattern_match_engine i_pattern_match_engine (
    .clk(clk), .rst(rst), .in_lines(in_lines), .normal_irq(normal_irq),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_out(irq_out), .rx_event(rx_event),
    .match_status(match_status)
  );

  localparam logic [31:0] SRC_EX  = {8'h00, 3'd7, 3'd5, 3'd6, 3'd3, 3'd2, 3'd2, 3'd1, 3'd1};
  localparam logic [31:0] CFG_EX  = {3'b111, 3'b000, 3'b010, 3'b101, 3'b101, 3'b000, 3'b000, 3'b000,
                                     1'b0, 7'b0100101};
  localparam logic [31:0] SRC_ID  = {8'h00, 3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
  localparam logic [31:0] CFG_TF  = {3'b110, {7{3'b100}}, 1'b0, 7'b0000001};
  localparam logic [31:0] CFG_RIS = {{7{3'b110}}, 3'b001, 1'b0, 7'b0000001};
  localparam logic [31:0] CFG_BTH = {{7{3'b110}}, 3'b011, 1'b0, 7'b0000001};
  localparam logic [31:0] CFG_LOW = {{7{3'b110}}, 3'b101, 1'b0, 7'b0000001};

  localparam int NV = 10;
  localparam logic [31:0] V_SRC [NV] = '{SRC_EX, SRC_EX, SRC_EX, SRC_ID, SRC_ID,
                                         32'd0, 32'd3, 32'd4, 32'd4, 32'd2};
  localparam logic [31:0] V_CFG [NV] = '{CFG_EX, CFG_EX, CFG_EX, 32'd0, 32'd0,
                                         CFG_TF, CFG_RIS, CFG_BTH, CFG_RIS, CFG_LOW};
  localparam logic [7:0]  V_A   [NV] = '{8'h40, 8'h00, 8'h20, 8'h00, 8'h00,
                                         8'h00, 8'h00, 8'h10, 8'h10, 8'hFF};
  localparam logic [7:0]  V_B   [NV] = '{8'h00, 8'h06, 8'hA0, 8'hFF, 8'h7F,
                                         8'h00, 8'h08, 8'h00, 8'h00, 8'hFB};
  localparam logic [7:0]  V_E1  [NV] = '{8'h20, 8'h05, 8'h80, 8'h80, 8'h00,
                                         8'h01, 8'h01, 8'h01, 8'h00, 8'h01};
  localparam logic [7:0]  V_E2  [NV] = '{8'h20, 8'h05, 8'h00, 8'h80, 8'h00,
                                         8'h01, 8'h01, 8'h01, 8'h00, 8'h01};
  localparam string V_REQ [NV] = '{"R4 R6", "R2 R6", "R3 R6", "R1 R6", "R2 R6",
                                   "R2 R6", "R4", "R4", "R4", "R2"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
  endtask

  task automatic restart(input logic [7:0] held);
    @(negedge clk);
    in_lines = held; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10 status", 32'(match_status), 32'h0);
    check("R10 irq", 32'(irq_out), 32'h0);
    check("R10 rx", 32'(rx_event), 32'h0);
    rst = 1'b0;
    rd(2'd1); check("R10 src reg", rd_data, 32'h0);
    rd(2'd2); check("R10 cfg reg", rd_data, 32'h0);

    // Table walk: R1 R2 R3 R4 R6, irq follows match (R7)
    for (int v = 0; v < NV; v++) begin
      restart(V_A[v]);
      wr(2'd1, V_SRC[v]);
      wr(2'd2, V_CFG[v]);
      wr(2'd0, 32'h3);
      @(negedge clk);
      in_lines = V_B[v];
      @(negedge clk);
      check({V_REQ[v], " first"}, 32'(match_status), 32'(V_E1[v]));
      check("R7 irq follows match", 32'(irq_out), 32'(V_E1[v]));
      @(negedge clk);
      check({V_REQ[v], " held"}, 32'(match_status), 32'(V_E2[v]));
    end

    // R5: rewriting a nonzero source field clears the latch
    restart(8'h00);
    wr(2'd1, 32'd3); wr(2'd2, CFG_RIS); wr(2'd0, 32'h1);
    @(negedge clk); in_lines = 8'h08;
    @(negedge clk); check("R5 latched", 32'(match_status), 32'h01);
    wr(2'd1, 32'd3);
    @(negedge clk); check("R5 cleared by src write", 32'(match_status), 32'h00);

    // R5: unchanged zero field keeps latch; changed condition clears it
    restart(8'h00);
    wr(2'd1, 32'd0); wr(2'd2, CFG_RIS); wr(2'd0, 32'h1);
    @(negedge clk); in_lines = 8'h01;
    @(negedge clk); check("R5 latched on input 0", 32'(match_status), 32'h01);
    wr(2'd1, 32'd0);
    @(negedge clk); check("R5 zero write ignored", 32'(match_status), 32'h01);
    wr(2'd2, CFG_BTH);
    @(negedge clk); check("R5 cleared by cond change", 32'(match_status), 32'h00);

    // R9: register reads
    rd(2'd2); check("R9 cfg readback", rd_data, CFG_BTH);
    rd(2'd0); check("R9 ctrl readback", rd_data, 32'h1);

    // R8: receive-event pulse
    restart(8'h00);
    wr(2'd1, SRC_EX); wr(2'd2, CFG_EX); wr(2'd0, 32'h3);
    @(negedge clk); in_lines = 8'h06;
    @(negedge clk); check("R8 rx pulse", 32'(rx_event), 32'h1);
    @(negedge clk); check("R8 rx one clock", 32'(rx_event), 32'h0);
    rd(2'd0); check("R9 status in read", rd_data, 32'h0500_0003);
    in_lines = 8'h00;
    @(negedge clk);
    wr(2'd0, 32'h1);
    @(negedge clk); in_lines = 8'h06;
    @(negedge clk); check("R8 rx disabled", 32'(rx_event), 32'h0);
    check("R8 match still seen", 32'(match_status), 32'h05);

    // R7: normal interrupt path when select bit is clear
    wr(2'd0, 32'h0);
    normal_irq = 8'hA5;
    @(negedge clk); check("R7 normal path", 32'(irq_out), 32'hA5);

    // R10: held level through reset gives no edge
    restart(8'h08);
    wr(2'd1, 32'd3); wr(2'd2, CFG_BTH); wr(2'd0, 32'h1);
    @(negedge clk); check("R10 no edge after reset", 32'(match_status), 32'h00);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule